// File: doc/BRIEF.md
# CORDIC Quadrature Generator with Amplitude Scaling

This block turns a stream of phase words into matched sine and cosine samples. Every accepted phase word enters a pipeline of shift-and-add rotation stages. The pipeline returns the sine and cosine of that angle together, in the same cycle, as 16-bit fractional two's complement numbers. The phase accumulator that produces the phase words sits outside the block.

Each phase word carries a mode bit and a 16-bit signed scale value. When the mode bit is set, both outputs are multiplied by the scale value. The block then works as an amplitude modulator. It can also split incoming data into in-phase and quadrature parts, when the data is fed in through the scale input. The mode bit and the scale value travel down the pipeline with their own phase word, so a change of mode takes effect on exactly the sample it came with.

The input and output use valid/ready handshakes. The whole pipeline moves one step in any cycle where the output is taken (`out_ready` high) or the output register is empty. When the output holds a sample that is not taken, every stage freezes and `in_ready` drops. No sample is lost or duplicated. Each output bus has its own active-low enable. A disabled bus reads zero.

Top module: `quad_cordic_nco`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid` is 0, `in_ready` is 1 and both output buses read 0.
- R2: Phase word P is unsigned, with 65536 steps per full turn. With the mode bit low, `sin_out` and `cos_out` equal round(32768·sin(2πP/65536)) and round(32768·cos(2πP/65536)) within 8 LSB. Results clamp to the range [-32768, 32767], so a cosine of +1.0 reads 32767.
- R3: The top two phase bits pick the quadrant. The results are correct on both sides of each quadrant boundary (0x0000, 0x4000, 0x8000, 0xC000). With the mode bit low, sqrt(sin²+cos²) stays within 16 LSB of 32768.
- R4: With the mode bit low, the scale input has no effect: any scale value gives the unscaled result.
- R5: With the mode bit high, each output equals round(sample·scale/32768) within 8 LSB, where the scale S is signed and means S/32768. Its magnitude never exceeds |scale|+1.
- R6: The product of -1.0 and -1.0 (cosine at phase 0x8000, scale -32768) saturates to +32767 and does not wrap.
- R7: The mode bit and scale value are applied to the sample they arrived with. Alternating modes on consecutive samples alternate the outputs in step.
- R8: `in_ready` = `out_ready` OR NOT `out_valid`. While `out_valid` is high and `out_ready` is low, `out_valid` and both output buses hold their values. No sample is dropped or repeated.
- R9: `out_valid` rises 19 cycles (ITER+3) after the cycle in which an input is accepted. It lasts exactly one cycle per sample, and bubbles are kept.
- R10: `sin_oe_n` and `cos_oe_n` are active low. A high enable forces its own bus to 0 and leaves the other bus unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase word present |
| in_ready | output | 1 | Block accepts the phase word this cycle |
| in_phase | input | 16 | Phase word, one full turn per 65536 steps |
| in_mode | input | 1 | 1 = multiply outputs by `in_scale` |
| in_scale | input | 16 | Signed fractional scale value |
| out_valid | output | 1 | Sample present on the output buses |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| sin_oe_n | input | 1 | Sine bus enable, active low |
| cos_oe_n | input | 1 | Cosine bus enable, active low |
| sin_out | output | 16 | Sine sample, Q1.15 |
| cos_out | output | 16 | Cosine sample, Q1.15 |

## Verification
The checker assumes that reset is held high from time zero until the first edges have cleared the valid pipeline. It also assumes that the two enable pins do not change while a stalled sample is waiting. The unit-circle and scale-bound properties hold only if the rotation stages keep their accuracy budget. The stimulus therefore uses only 16-bit phase words and legal scale values, and it changes the enables only after the pipeline has drained. The bench holds `in_valid` and its payload steady until a handshake completes. It drives `out_ready` in a fixed pattern, so stall behaviour is covered without depending on the order of processes.

// File: rtl/cordic_nco_pkg.sv
package cordic_nco_pkg;

  // Angle resolution of the rotation stages, in steps per full turn (2**ANG_FRAC).
  localparam int ANG_FRAC = 20;

  typedef struct packed {
    logic valid;
    logic mode;
  } side_t;

  // Arctangent of 2**-idx expressed in turns * 2**ANG_FRAC.
  function automatic logic [ANG_FRAC-1:0] atan_turns(input int idx);
    case (idx)
      0:  return 20'd131072;
      1:  return 20'd77376;
      2:  return 20'd40884;
      3:  return 20'd20753;
      4:  return 20'd10417;
      5:  return 20'd5213;
      6:  return 20'd2607;
      7:  return 20'd1304;
      8:  return 20'd652;
      9:  return 20'd326;
      10: return 20'd163;
      11: return 20'd81;
      12: return 20'd41;
      13: return 20'd20;
      14: return 20'd10;
      15: return 20'd5;
      default: return 20'd0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_microrot.sv
module cordic_microrot
  import cordic_nco_pkg::*;
#(
  parameter int DW  = 20,
  parameter int AW  = 22,
  parameter int SW  = 16,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [AW-1:0] z_i,
  input  side_t                side_i,
  input  logic signed [SW-1:0] scale_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o,
  output side_t                side_o,
  output logic signed [SW-1:0] scale_o
);

  localparam logic signed [AW-1:0] STEP = $signed(AW'(atan_turns(IDX)));

  logic                 ccw;
  logic signed [DW-1:0] xs, ys;

  always_comb begin
    ccw = ~z_i[AW-1];
    xs  = x_i >>> IDX;
    ys  = y_i >>> IDX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
      side_o  <= '0;
      scale_o <= '0;
    end else if (adv) begin
      x_o     <= ccw ? (x_i - ys) : (x_i + ys);
      y_o     <= ccw ? (y_i + xs) : (y_i - xs);
      z_o     <= ccw ? (z_i - STEP) : (z_i + STEP);
      side_o  <= side_i;
      scale_o <= scale_i;
    end
  end

endmodule

// File: rtl/cordic_amp_scale.sv
module cordic_amp_scale #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] smp,
  input  logic signed [W-1:0] scale,
  input  logic                mode,
  output logic signed [W-1:0] res
);

  localparam logic signed [2*W:0] RND  = (2*W+1)'(1) <<< (W-2);
  localparam logic signed [2*W:0] PMAX = (2*W+1)'((1 << (W-1)) - 1);
  localparam logic signed [2*W:0] PMIN = -PMAX - (2*W+1)'(1);

  logic signed [2*W-1:0] prod;
  logic signed [2*W:0]   rnd, shf;
  logic signed [W-1:0]   sat;

  always_comb begin
    prod = $signed({{W{smp[W-1]}}, smp}) * $signed({{W{scale[W-1]}}, scale});
    rnd  = $signed({prod[2*W-1], prod}) + RND;
    shf  = rnd >>> (W-1);
    if (shf > PMAX)      sat = PMAX[W-1:0];
    else if (shf < PMIN) sat = PMIN[W-1:0];
    else                 sat = shf[W-1:0];
    res  = mode ? sat : smp;
  end

endmodule

// File: rtl/quad_cordic_nco.sv
module quad_cordic_nco
  import cordic_nco_pkg::*;
#(
  parameter int PW   = 16,  // phase word width, at most ANG_FRAC
  parameter int OW   = 16,  // sample and scale width
  parameter int DW   = 20,  // rotation datapath width
  parameter int ITER = 16   // micro-rotations
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PW-1:0]        in_phase,
  input  logic                 in_mode,
  input  logic signed [OW-1:0] in_scale,
  output logic                 out_valid,
  input  logic                 out_ready,
  input  logic                 sin_oe_n,
  input  logic                 cos_oe_n,
  output logic signed [OW-1:0] sin_out,
  output logic signed [OW-1:0] cos_out
);

  localparam int FRAC  = DW - 3;
  localparam int ANG_W = ANG_FRAC + 2;
  localparam int RES_W = PW - 2;
  localparam int SHZ   = ANG_FRAC - PW;
  localparam int SH    = FRAC - (OW - 1);   // must be at least 1
  localparam int LAT   = ITER + 3;

  localparam logic signed [DW-1:0] X_START =
    DW'($rtoi(0.6072529350088813 * (2.0 ** FRAC) + 0.5));
  localparam logic signed [DW:0] RND_O = (DW+1)'(1) <<< (SH-1);
  localparam logic signed [DW:0] O_MAX = (DW+1)'((1 << (OW-1)) - 1);
  localparam logic signed [DW:0] O_MIN = -O_MAX - (DW+1)'(1);

  function automatic logic signed [OW-1:0] to_sample(input logic signed [DW-1:0] v);
    logic signed [DW:0] r, s;
    r = $signed({v[DW-1], v}) + RND_O;
    s = r >>> SH;
    if (s > O_MAX)      return O_MAX[OW-1:0];
    else if (s < O_MIN) return O_MIN[OW-1:0];
    else                return s[OW-1:0];
  endfunction

  logic adv;

  logic signed [DW-1:0]    x_s     [ITER+1];
  logic signed [DW-1:0]    y_s     [ITER+1];
  logic signed [ANG_W-1:0] z_s     [ITER+1];
  side_t                   side_s  [ITER+1];
  logic signed [OW-1:0]    scale_s [ITER+1];

  logic signed [OW-1:0] rnd_sin, rnd_cos, rnd_scale;
  side_t                rnd_side;
  logic signed [OW-1:0] am_sin, am_cos;

  logic signed [OW-1:0] out_sin_q, out_cos_q, out_scale_q;
  logic                 out_mode_q, out_valid_q;

  assign adv      = out_ready | ~out_valid_q;
  assign in_ready = adv;

  // Stage 0: quadrant pre-rotation and residual angle
  always_ff @(posedge clk) begin
    if (rst) begin
      x_s[0]     <= '0;
      y_s[0]     <= '0;
      z_s[0]     <= '0;
      side_s[0]  <= '0;
      scale_s[0] <= '0;
    end else if (adv) begin
      side_s[0]  <= '{valid: in_valid, mode: in_mode};
      scale_s[0] <= in_scale;
      z_s[0]     <= $signed(ANG_W'(in_phase[RES_W-1:0])) <<< SHZ;
      case (in_phase[PW-1 -: 2])
        2'd0: begin x_s[0] <=  X_START; y_s[0] <= '0;       end
        2'd1: begin x_s[0] <= '0;       y_s[0] <=  X_START; end
        2'd2: begin x_s[0] <= -X_START; y_s[0] <= '0;       end
        default: begin x_s[0] <= '0;    y_s[0] <= -X_START; end
      endcase
    end
  end

  for (genvar i = 0; i < ITER; i++) begin : g_rot
    cordic_microrot #(.DW(DW), .AW(ANG_W), .SW(OW), .IDX(i)) u_rot (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .x_i     (x_s[i]),
      .y_i     (y_s[i]),
      .z_i     (z_s[i]),
      .side_i  (side_s[i]),
      .scale_i (scale_s[i]),
      .x_o     (x_s[i+1]),
      .y_o     (y_s[i+1]),
      .z_o     (z_s[i+1]),
      .side_o  (side_s[i+1]),
      .scale_o (scale_s[i+1])
    );
  end

  // Rounding stage (the residual angle of the last stage is dropped)
  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_sin   <= '0;
      rnd_cos   <= '0;
      rnd_scale <= '0;
      rnd_side  <= '0;
    end else if (adv) begin
      rnd_sin   <= to_sample(y_s[ITER]);
      rnd_cos   <= to_sample(x_s[ITER]);
      rnd_scale <= scale_s[ITER];
      rnd_side  <= side_s[ITER];
    end
  end

  cordic_amp_scale #(.W(OW)) u_am_sin (
    .smp(rnd_sin), .scale(rnd_scale), .mode(rnd_side.mode), .res(am_sin));
  cordic_amp_scale #(.W(OW)) u_am_cos (
    .smp(rnd_cos), .scale(rnd_scale), .mode(rnd_side.mode), .res(am_cos));

  // Output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_sin_q   <= '0;
      out_cos_q   <= '0;
      out_scale_q <= '0;
      out_mode_q  <= 1'b0;
      out_valid_q <= 1'b0;
    end else if (adv) begin
      out_sin_q   <= am_sin;
      out_cos_q   <= am_cos;
      out_scale_q <= rnd_scale;
      out_mode_q  <= rnd_side.mode;
      out_valid_q <= rnd_side.valid;
    end
  end

  assign out_valid = out_valid_q;
  assign sin_out   = sin_oe_n ? '0 : out_sin_q;
  assign cos_out   = cos_oe_n ? '0 : out_cos_q;

  logic unused_ok;
  assign unused_ok = ^z_s[ITER];

endmodule

// File: rtl/quad_cordic_nco_chk.sv
module quad_cordic_nco_chk #(
  parameter int LAT = 19,
  parameter int OW  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [OW-1:0] out_sin_q,
  input logic signed [OW-1:0] out_cos_q,
  input logic                 out_mode_q,
  input logic signed [OW-1:0] out_scale_q
);

  localparam longint FS   = longint'(1) << (OW-1);
  localparam longint R_LO = (FS - 16) * (FS - 16);
  localparam longint R_HI = (FS + 16) * (FS + 16);

  logic [LAT-1:0] vpipe;
  longint         s_l, c_l, k_l, mag2, abs_s, abs_c, abs_k;

  always_ff @(posedge clk) begin
    if (rst)           vpipe <= '0;
    else if (in_ready) vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  always_comb begin
    s_l   = longint'(out_sin_q);
    c_l   = longint'(out_cos_q);
    k_l   = longint'(out_scale_q);
    mag2  = s_l * s_l + c_l * c_l;
    abs_s = (s_l < 0) ? -s_l : s_l;
    abs_c = (c_l < 0) ? -c_l : c_l;
    abs_k = (k_l < 0) ? -k_l : k_l;
  end

  // R9: a valid flag leaves the pipeline after exactly LAT accepted steps
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[LAT-1]);

  // R8: a waiting sample keeps the input closed
  assert_no_accept_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: a waiting sample is held unchanged
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sin_q) && $stable(out_cos_q)));

  // R3: unscaled samples lie on the unit circle
  assert_unit_circle_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_mode_q) |-> (mag2 >= R_LO && mag2 <= R_HI));

  // R5: scaled samples never exceed the scale magnitude
  assert_scale_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode_q) |-> (abs_s <= abs_k + 1 && abs_c <= abs_k + 1));

endmodule

bind quad_cordic_nco quad_cordic_nco_chk #(.LAT(LAT), .OW(OW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_sin_q   (out_sin_q),
  .out_cos_q   (out_cos_q),
  .out_mode_q  (out_mode_q),
  .out_scale_q (out_scale_q)
);

// File: tb/test_quad_cordic_nco.sv
module test_quad_cordic_nco;

  localparam int LAT  = 19;
  localparam int TOL  = 8;
  localparam int HALF = 10;  // 20 ns period, 50 MHz
  localparam int QPH [12] = '{'h0000, 'h0001, 'h3fff, 'h4000, 'h4001, 'h7fff,
                              'h8000, 'h8001, 'hbfff, 'hc000, 'hc001, 'hffff};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid, in_ready, in_mode, out_valid, out_ready;
  logic               sin_oe_n, cos_oe_n;
  logic [15:0]        in_phase;
  logic signed [15:0] in_scale, sin_out, cos_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  logic [32:0] expq [$];
  bit          stalled = 1'b0;
  logic signed [15:0] held_sin, held_cos;

  always #HALF clk = ~clk;

  quad_cordic_nco i_quad_cordic_nco (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .in_mode(in_mode), .in_scale(in_scale),
    .out_valid(out_valid), .out_ready(out_ready),
    .sin_oe_n(sin_oe_n), .cos_oe_n(cos_oe_n),
    .sin_out(sin_out), .cos_out(cos_out));

  function automatic int ideal(input logic [15:0] ph, input logic md,
                               input logic signed [15:0] sc, input bit want_sin);
    real a, v, r;
    int  q;
    a = 6.283185307179586 * real'(ph) / 65536.0;
    v = want_sin ? $sin(a) : $cos(a);
    r = md ? v * real'(sc) : v * 32768.0;
    q = $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check_tol(string req, string what, int act, int exp, int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    n_tests++;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  // Monitor: sampled on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      stalled = 1'b0;
    end else begin
      if (stalled) begin
        check_tol("R8", "held valid", int'(out_valid), 1, 0);
        check_tol("R8", "held sin", int'(sin_out), int'(held_sin), 0);
        check_tol("R8", "held cos", int'(cos_out), int'(held_cos), 0);
      end
      if (out_valid && !out_ready)
        check_tol("R8", "in_ready during stall", int'(in_ready), 0, 0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check_tol(cur_req, "unexpected sample", 1, 0, 0);
        end else begin
          logic [32:0] e;
          int es, ec;
          e  = expq.pop_front();
          es = sin_oe_n ? 0 : ideal(e[15:0], e[32], e[31:16], 1'b1);
          ec = cos_oe_n ? 0 : ideal(e[15:0], e[32], e[31:16], 1'b0);
          check_tol(cur_req, "sin", int'(sin_out), es, sin_oe_n ? 0 : TOL);
          check_tol(cur_req, "cos", int'(cos_out), ec, cos_oe_n ? 0 : TOL);
          if (cur_req == "R3") begin
            real m;
            m = $sqrt(real'(sin_out) * real'(sin_out) + real'(cos_out) * real'(cos_out));
            check_tol("R3", "magnitude", $rtoi(m + 0.5), 32768, 16);
          end
        end
      end
      if (in_valid && in_ready) expq.push_back({in_mode, in_scale, in_phase});
      stalled  = out_valid && !out_ready;
      held_sin = sin_out;
      held_cos = cos_out;
    end
  end

  task automatic send(input logic [15:0] ph, input logic md, input logic signed [15:0] sc);
    @(posedge clk); #2;
    in_valid = 1'b1; in_phase = ph; in_mode = md; in_scale = sc;
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic idle();
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (expq.size() == 0) break;
    end
    check_tol(cur_req, "pending samples after drain", expq.size(), 0, 0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_tol("R1", "out_valid in reset", int'(out_valid), 0, 0);
    @(posedge clk); #2; rst = 1'b0;
    @(negedge clk);
    check_tol("R1", "out_valid after reset", int'(out_valid), 0, 0);
    check_tol("R1", "in_ready after reset", int'(in_ready), 1, 0);
    check_tol("R1", "sin after reset", int'(sin_out), 0, 0);
    check_tol("R1", "cos after reset", int'(cos_out), 0, 0);
  endtask

  task automatic t_sweep();
    cur_req = "R2";
    for (int k = 0; k < 64; k++) send(16'(k * 1031 + 7), 1'b0, 16'sd0);
    send(16'h0000, 1'b0, 16'sd0);  // cosine clamps to 32767
    drain();
  endtask

  task automatic t_quadrants();
    cur_req = "R3";
    for (int k = 0; k < 12; k++) send(16'(QPH[k]), 1'b0, 16'sd0);
    drain();
  endtask

  task automatic t_scale_ignored();
    cur_req = "R4";
    send(16'h1234, 1'b0, 16'sd0);
    send(16'h1234, 1'b0, -16'sd32768);
    send(16'h1234, 1'b0, 16'sd12345);
    send(16'hA5A5, 1'b0, 16'sd1);
    drain();
  endtask

  task automatic t_am();
    cur_req = "R5";
    send(16'h0800, 1'b1, 16'sd32767);
    send(16'h2222, 1'b1, 16'sd16384);
    send(16'h6000, 1'b1, -16'sd20000);
    send(16'h9abc, 1'b1, 16'sd1);
    send(16'hd000, 1'b1, 16'sd0);
    send(16'hf123, 1'b1, -16'sd7777);
    drain();
  endtask

  task automatic t_saturate();
    cur_req = "R6";
    send(16'h8000, 1'b1, -16'sd32768);  // cos -1.0 times -1.0
    send(16'h0000, 1'b1, -16'sd32768);
    drain();
  endtask

  task automatic t_mode_mix();
    cur_req = "R7";
    for (int k = 0; k < 12; k++) send(16'(k * 5000), 1'(k % 2), 16'sd8192);
    drain();
  endtask

  task automatic t_backpressure();
    cur_req = "R8";
    fork
      begin
        for (int k = 0; k < 30; k++) send(16'(k * 2111), 1'(k % 3 == 0), 16'sd20000);
        idle();
      end
      begin
        for (int k = 0; k < 80; k++) begin
          @(posedge clk); #2;
          out_ready = (k % 3) != 1 && (k % 7) != 3;
        end
        @(posedge clk); #2;
        out_ready = 1'b1;
      end
    join
    drain();
  endtask

  task automatic t_latency();
    int n;
    cur_req = "R9";
    @(posedge clk); #2;
    in_valid = 1'b1; in_phase = 16'h3000; in_mode = 1'b0; in_scale = '0;
    @(negedge clk);
    check_tol("R9", "in_ready on empty pipe", int'(in_ready), 1, 0);
    @(posedge clk); #2; in_valid = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 40);
    check_tol("R9", "latency", n, LAT, 0);
    @(negedge clk);
    check_tol("R9", "single-cycle valid", int'(out_valid), 0, 0);
    drain();
  endtask

  task automatic t_oe();
    cur_req = "R10";
    @(posedge clk); #2; sin_oe_n = 1'b1;
    for (int k = 0; k < 6; k++) send(16'(k * 9000 + 300), 1'b0, 16'sd0);
    drain();
    @(posedge clk); #2; sin_oe_n = 1'b0; cos_oe_n = 1'b1;
    for (int k = 0; k < 6; k++) send(16'(k * 9000 + 300), 1'b1, 16'sd30000);
    drain();
    @(posedge clk); #2; cos_oe_n = 1'b0;
  endtask

  initial begin
    in_valid = 1'b0; in_phase = '0; in_mode = 1'b0; in_scale = '0;
    out_ready = 1'b1; sin_oe_n = 1'b0; cos_oe_n = 1'b0;
    t_reset();
    t_sweep();
    t_quadrants();
    t_scale_ignored();
    t_am();
    t_saturate();
    t_mode_mix();
    t_backpressure();
    t_latency();
    t_oe();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(2 * HALF * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule